// File: doc/BRIEF.md
# Register-Remapping Vector Element Sequencer

This block turns one decoded three-operand scalar instruction into a run of per-element scalar operations. No vector register file exists. Software fills a small tag table that marks chosen architectural registers as vector operands and gives each one a starting physical register. A tagged operand then names the first register of a contiguous run: element i uses the start plus i. Operands with no tag keep the same register number for every element.

A second table, the predicate table, lets the destination register of an instruction select a mask register. The sequencer shows that register number on `pred_addr`, samples its value from `pred_bits` when it accepts the instruction, and marks each element as enabled or suppressed. Elements leave strictly in ascending order, one per handshake. After an enabled element the block waits for its write-back before it issues the next one, so overlapping source and destination runs give the sequential result. When an enabled element faults, the index of that element is kept per privilege mode so that the next instruction in that mode resumes from it.

Tables and saved indices are held separately for user, supervisor and machine mode. Register numbers that would run past the end of the register file are flagged as illegal and never wrap.

Top module: `vs_seq`

## Requirements
- R1: After reset `in_ready` is 1, `el_valid`, `ill` and `el_en` are 0 and `resume_idx` is 0.
- R2: When an instruction runs as a vector, a tagged operand gives register start+i for element i, and an untagged operand keeps its own number for every element.
- R3: A tag entry matches only when the register number and the class in `in_fp` (0 integer, 1 floating point) both agree, and its `cfg_dest` field sets the start register, which may differ from the architectural number.
- R4: When `in_vl` is 0 or 1, or no operand of the instruction is tagged, exactly one element is issued with index 0, `el_last`=1, `el_en`=1 and the unmodified register numbers.
- R5: When the destination of a vector instruction matches a valid predicate entry, `pred_addr` shows that entry's `cfg_dest` during the request, and element i has `el_en` equal to bit i of `pred_bits`; with no match `pred_addr` is 0 and every element is enabled. Suppressed elements still appear with `el_en`=0.
- R6: Elements appear in ascending index order starting at the start index, one per accepted handshake, `el_last` is 1 only on the final element, and `in_ready` is 0 while elements remain.
- R7: After an enabled element is accepted, `el_valid` stays 0 until `wb_ack` is seen; after a suppressed element the next one follows in the next cycle.
- R8: `fault` during the wait of an enabled element ends the instruction with no further elements and sets the mode's `resume_idx` to that element's index; the next instruction in that mode starts from that index, and a completed instruction returns the mode's `resume_idx` to 0.
- R9: `priv_mode` selects the tables and saved index (0 user, 1 supervisor, 2 machine); writes with `cfg_mode`=3 are dropped, and an entry written for one mode has no effect in another.
- R10: A vector instruction whose length exceeds 16, or whose tagged run start+`in_vl`-1 exceeds 31, is accepted, raises `ill` for one cycle and issues no element.
- R11: When several valid tag entries match the same operand, the one with the lowest slot number supplies the start register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 tag table, 1 predicate table |
| cfg_mode | input | 2 | Privilege mode whose table is written (3 dropped) |
| cfg_slot | input | 4 | Entry slot |
| cfg_valid | input | 1 | Entry valid |
| cfg_fp | input | 1 | Entry register class |
| cfg_arch | input | 5 | Architectural register the entry matches |
| cfg_dest | input | 5 | Start register (tag) or mask register (predicate) |
| priv_mode | input | 2 | Current privilege mode |
| in_valid | input | 1 | Instruction request |
| in_ready | output | 1 | Sequencer idle and able to accept |
| in_fp | input | 1 | Instruction register class |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| in_vl | input | 5 | Vector length |
| pred_addr | output | 5 | Mask register to read, 0 if none |
| pred_bits | input | 16 | Mask register value, one bit per element |
| el_valid | output | 1 | Element operation valid |
| el_ready | input | 1 | Element operation taken |
| el_idx | output | 4 | Element index |
| el_fp | output | 1 | Element register class |
| el_rd | output | 5 | Physical destination |
| el_rs1 | output | 5 | Physical first source |
| el_rs2 | output | 5 | Physical second source |
| el_en | output | 1 | Element enabled (0 suppressed) |
| el_last | output | 1 | Final element of the instruction |
| wb_ack | input | 1 | Write-back of the enabled element done |
| fault | input | 1 | Enabled element raised an exception |
| ill | output | 1 | Illegal register range pulse |
| resume_idx | output | 4 | Saved element index of the current mode |

## Verification
A corrupted element counter shows up at once as a wrong `el_idx` and wrong physical register numbers on the very element that follows, since every register field is derived from it. A lost or stale saved index surfaces only at the next instruction in the affected mode, either through `resume_idx` after a mode switch or as a run that starts at the wrong element, so the tests interleave faults with mode changes. A state machine that skips the write-back wait would put a second element on the port during the cycle in which only silence is allowed, which the bench inspects after every enabled element.

// File: rtl/vs_seq_pkg.sv
package vs_seq_pkg;
  localparam int NMODE = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_e;

  localparam logic SEL_TAG  = 1'b0;
  localparam logic SEL_PRED = 1'b1;
endpackage

// File: rtl/vs_map_table.sv
module vs_map_table
  import vs_seq_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NTAG  = 16,
  parameter int NLOOK = 1,
  localparam int RW = $clog2(NREG),
  localparam int TW = $clog2(NTAG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_mode,
  input  logic [TW-1:0]      wr_slot,
  input  logic               wr_valid,
  input  logic               wr_fp,
  input  logic [RW-1:0]      wr_arch,
  input  logic [RW-1:0]      wr_dest,
  input  logic [1:0]         lk_mode,
  input  logic [NLOOK-1:0]   lk_fp,
  input  logic [NLOOK*RW-1:0] lk_arch,
  output logic [NLOOK-1:0]   lk_hit,
  output logic [NLOOK*RW-1:0] lk_dest
);
  logic [NTAG-1:0] ent_v    [NMODE];
  logic [NTAG-1:0] ent_fp   [NMODE];
  logic [RW-1:0]   ent_arch [NMODE][NTAG];
  logic [RW-1:0]   ent_dest [NMODE][NTAG];

  logic wr_ok;
  logic lk_ok;

  // write decode: only the three defined privilege modes own a table
  always_comb begin
    wr_ok = wr_en && (wr_mode < 2'(NMODE));
    lk_ok = (lk_mode < 2'(NMODE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NMODE; m++) begin
        ent_v[m]  <= '0;
        ent_fp[m] <= '0;
        for (int e = 0; e < NTAG; e++) begin
          ent_arch[m][e] <= '0;
          ent_dest[m][e] <= '0;
        end
      end
    end else if (wr_ok) begin
      ent_v[wr_mode][wr_slot]    <= wr_valid;
      ent_fp[wr_mode][wr_slot]   <= wr_fp;
      ent_arch[wr_mode][wr_slot] <= wr_arch;
      ent_dest[wr_mode][wr_slot] <= wr_dest;
    end
  end

  // parallel associative lookup, one lane per operand; lowest slot wins
  for (genvar g = 0; g < NLOOK; g++) begin : g_lane
    logic          hit_g;
    logic [RW-1:0] dst_g;

    always_comb begin
      hit_g = 1'b0;
      dst_g = '0;
      if (lk_ok) begin
        for (int e = NTAG - 1; e >= 0; e--) begin
          if (ent_v[lk_mode][e] &&
              (ent_fp[lk_mode][e] == lk_fp[g]) &&
              (ent_arch[lk_mode][e] == lk_arch[g*RW +: RW])) begin
            hit_g = 1'b1;
            dst_g = ent_dest[lk_mode][e];
          end
        end
      end
    end

    assign lk_hit[g]           = hit_g;
    assign lk_dest[g*RW +: RW] = dst_g;
  end
endmodule

// File: rtl/vs_op_decode.sv
module vs_op_decode #(
  parameter int NREG  = 32,
  parameter int MAXVL = 16,
  localparam int RW  = $clog2(NREG),
  localparam int VLW = $clog2(MAXVL + 1),
  localparam int SW  = RW + VLW + 1
) (
  input  logic [3*RW-1:0]  op_reg,
  input  logic [2:0]       op_hit,
  input  logic [3*RW-1:0]  op_dest,
  input  logic [VLW-1:0]   vl,
  input  logic             pred_hit,
  input  logic [MAXVL-1:0] pred_bits,
  output logic [3*RW-1:0]  base,
  output logic [2:0]       vec,
  output logic [VLW-1:0]   n_elem,
  output logic [MAXVL-1:0] mask,
  output logic             illegal
);
  logic          multi;
  logic [SW-1:0] run_end;

  always_comb begin
    multi   = (|op_hit) && (vl > VLW'(1));
    vec     = multi ? op_hit : 3'b000;
    n_elem  = multi ? vl : VLW'(1);
    mask    = (multi && pred_hit) ? pred_bits : '1;
    illegal = multi && (vl > VLW'(MAXVL));
    run_end = '0;
    for (int k = 0; k < 3; k++) begin
      base[k*RW +: RW] = vec[k] ? op_dest[k*RW +: RW] : op_reg[k*RW +: RW];
      run_end = SW'(base[k*RW +: RW]) + SW'(vl) - SW'(1);
      if (vec[k] && (run_end >= SW'(NREG))) begin
        illegal = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vs_elem_ctrl.sv
module vs_elem_ctrl
  import vs_seq_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int MAXVL = 16,
  localparam int RW  = $clog2(NREG),
  localparam int IW  = $clog2(MAXVL),
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic             in_fp,
  input  logic [3*RW-1:0]  dec_base,
  input  logic [2:0]       dec_vec,
  input  logic [VLW-1:0]   dec_n,
  input  logic [MAXVL-1:0] dec_mask,
  input  logic             dec_illegal,
  input  logic [1:0]       view_mode,
  input  logic             el_ready,
  input  logic             wb_ack,
  input  logic             fault,
  output logic             in_ready,
  output logic             el_valid,
  output logic [IW-1:0]    el_idx,
  output logic             el_fp,
  output logic [RW-1:0]    el_rd,
  output logic [RW-1:0]    el_rs1,
  output logic [RW-1:0]    el_rs2,
  output logic             el_en,
  output logic             el_last,
  output logic             ill,
  output logic [IW-1:0]    resume_idx
);
  sq_state_e        st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [VLW-1:0]   n_q, n_d;
  logic [3*RW-1:0]  base_q, base_d;
  logic [2:0]       vec_q, vec_d;
  logic [MAXVL-1:0] mask_q, mask_d;
  logic             fp_q, fp_d;
  logic [1:0]       mode_q, mode_d;
  logic             ill_q, ill_d;
  logic [IW-1:0]    sav_q [NMODE];
  logic [IW-1:0]    sav_d [NMODE];

  logic          accept;
  logic          last;
  logic          clr_sav;
  logic          set_sav;
  logic [IW-1:0] sav_in;
  logic [IW-1:0] start_idx;

  // next-state logic
  always_comb begin
    accept = in_valid && (st_q == SQ_IDLE);
    last   = ((VLW'(idx_q) + VLW'(1)) == n_q);

    sav_in = '0;
    for (int m = 0; m < NMODE; m++) begin
      if (in_mode == 2'(m)) sav_in = sav_q[m];
    end
    start_idx = (VLW'(sav_in) < dec_n) ? sav_in : '0;

    st_d    = st_q;
    idx_d   = idx_q;
    n_d     = n_q;
    base_d  = base_q;
    vec_d   = vec_q;
    mask_d  = mask_q;
    fp_d    = fp_q;
    mode_d  = mode_q;
    ill_d   = 1'b0;
    clr_sav = 1'b0;
    set_sav = 1'b0;

    case (st_q)
      SQ_IDLE: begin
        if (accept) begin
          if (dec_illegal) begin
            ill_d = 1'b1;
          end else begin
            st_d   = SQ_ISSUE;
            idx_d  = start_idx;
            n_d    = dec_n;
            base_d = dec_base;
            vec_d  = dec_vec;
            mask_d = dec_mask;
            fp_d   = in_fp;
            mode_d = in_mode;
          end
        end
      end
      SQ_ISSUE: begin
        if (el_ready) begin
          if (mask_q[idx_q]) begin
            st_d = SQ_WAIT;
          end else if (last) begin
            st_d    = SQ_IDLE;
            clr_sav = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      SQ_WAIT: begin
        if (fault) begin
          st_d    = SQ_IDLE;
          set_sav = 1'b1;
        end else if (wb_ack) begin
          if (last) begin
            st_d    = SQ_IDLE;
            clr_sav = 1'b1;
          end else begin
            st_d  = SQ_ISSUE;
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase

    for (int m = 0; m < NMODE; m++) begin
      sav_d[m] = sav_q[m];
      if (mode_q == 2'(m)) begin
        if (clr_sav) sav_d[m] = '0;
        if (set_sav) sav_d[m] = idx_q;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      n_q    <= '0;
      base_q <= '0;
      vec_q  <= '0;
      mask_q <= '0;
      fp_q   <= 1'b0;
      mode_q <= '0;
      ill_q  <= 1'b0;
      for (int m = 0; m < NMODE; m++) sav_q[m] <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      n_q    <= n_d;
      base_q <= base_d;
      vec_q  <= vec_d;
      mask_q <= mask_d;
      fp_q   <= fp_d;
      mode_q <= mode_d;
      ill_q  <= ill_d;
      for (int m = 0; m < NMODE; m++) sav_q[m] <= sav_d[m];
    end
  end

  // element output formation
  always_comb begin
    in_ready = (st_q == SQ_IDLE);
    el_valid = (st_q == SQ_ISSUE);
    el_idx   = idx_q;
    el_fp    = fp_q;
    el_rd    = base_q[0*RW +: RW] + (vec_q[0] ? RW'(idx_q) : '0);
    el_rs1   = base_q[1*RW +: RW] + (vec_q[1] ? RW'(idx_q) : '0);
    el_rs2   = base_q[2*RW +: RW] + (vec_q[2] ? RW'(idx_q) : '0);
    el_en    = el_valid && mask_q[idx_q];
    el_last  = el_valid && last;
    ill      = ill_q;
    resume_idx = '0;
    for (int m = 0; m < NMODE; m++) begin
      if (view_mode == 2'(m)) resume_idx = sav_q[m];
    end
  end
endmodule

// File: rtl/vs_seq.sv
module vs_seq
  import vs_seq_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NTAG  = 16,
  parameter int MAXVL = 16,
  localparam int RW  = $clog2(NREG),
  localparam int TW  = $clog2(NTAG),
  localparam int IW  = $clog2(MAXVL),
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [1:0]       cfg_mode,
  input  logic [TW-1:0]    cfg_slot,
  input  logic             cfg_valid,
  input  logic             cfg_fp,
  input  logic [RW-1:0]    cfg_arch,
  input  logic [RW-1:0]    cfg_dest,
  input  logic [1:0]       priv_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_fp,
  input  logic [RW-1:0]    in_rd,
  input  logic [RW-1:0]    in_rs1,
  input  logic [RW-1:0]    in_rs2,
  input  logic [VLW-1:0]   in_vl,
  output logic [RW-1:0]    pred_addr,
  input  logic [MAXVL-1:0] pred_bits,
  output logic             el_valid,
  input  logic             el_ready,
  output logic [IW-1:0]    el_idx,
  output logic             el_fp,
  output logic [RW-1:0]    el_rd,
  output logic [RW-1:0]    el_rs1,
  output logic [RW-1:0]    el_rs2,
  output logic             el_en,
  output logic             el_last,
  input  logic             wb_ack,
  input  logic             fault,
  output logic             ill,
  output logic [IW-1:0]    resume_idx
);
  logic [3*RW-1:0]  op_reg;
  logic [2:0]       tag_hit;
  logic [3*RW-1:0]  tag_dest;
  logic [0:0]       prd_hit;
  logic [RW-1:0]    prd_dest;
  logic [3*RW-1:0]  dec_base;
  logic [2:0]       dec_vec;
  logic [VLW-1:0]   dec_n;
  logic [MAXVL-1:0] dec_mask;
  logic             dec_illegal;
  logic             tag_we;
  logic             prd_we;

  assign op_reg    = {in_rs2, in_rs1, in_rd};
  assign tag_we    = cfg_we && (cfg_sel == SEL_TAG);
  assign prd_we    = cfg_we && (cfg_sel == SEL_PRED);
  assign pred_addr = prd_hit[0] ? prd_dest : '0;

  vs_map_table #(.NREG(NREG), .NTAG(NTAG), .NLOOK(3)) u_tag (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tag_we), .wr_mode(cfg_mode), .wr_slot(cfg_slot),
    .wr_valid(cfg_valid), .wr_fp(cfg_fp), .wr_arch(cfg_arch), .wr_dest(cfg_dest),
    .lk_mode(priv_mode), .lk_fp({3{in_fp}}), .lk_arch(op_reg),
    .lk_hit(tag_hit), .lk_dest(tag_dest)
  );

  vs_map_table #(.NREG(NREG), .NTAG(NTAG), .NLOOK(1)) u_pred (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prd_we), .wr_mode(cfg_mode), .wr_slot(cfg_slot),
    .wr_valid(cfg_valid), .wr_fp(cfg_fp), .wr_arch(cfg_arch), .wr_dest(cfg_dest),
    .lk_mode(priv_mode), .lk_fp(in_fp), .lk_arch(in_rd),
    .lk_hit(prd_hit), .lk_dest(prd_dest)
  );

  vs_op_decode #(.NREG(NREG), .MAXVL(MAXVL)) u_dec (
    .op_reg(op_reg), .op_hit(tag_hit), .op_dest(tag_dest), .vl(in_vl),
    .pred_hit(prd_hit[0]), .pred_bits(pred_bits),
    .base(dec_base), .vec(dec_vec), .n_elem(dec_n), .mask(dec_mask),
    .illegal(dec_illegal)
  );

  vs_elem_ctrl #(.NREG(NREG), .MAXVL(MAXVL)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_mode(priv_mode), .in_fp(in_fp),
    .dec_base(dec_base), .dec_vec(dec_vec), .dec_n(dec_n),
    .dec_mask(dec_mask), .dec_illegal(dec_illegal),
    .view_mode(priv_mode), .el_ready(el_ready), .wb_ack(wb_ack), .fault(fault),
    .in_ready(in_ready), .el_valid(el_valid), .el_idx(el_idx), .el_fp(el_fp),
    .el_rd(el_rd), .el_rs1(el_rs1), .el_rs2(el_rs2), .el_en(el_en),
    .el_last(el_last), .ill(ill), .resume_idx(resume_idx)
  );
endmodule

// File: rtl/vs_seq_chk.sv
module vs_seq_chk #(
  parameter int IW = 4,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          el_valid,
  input logic          el_ready,
  input logic          el_en,
  input logic          el_last,
  input logic [IW-1:0] el_idx,
  input logic [RW-1:0] el_rd,
  input logic          fault,
  input logic          ill
);
  AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid |-> !in_ready); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (el_valid && el_ready && !el_en && !el_last) |=>
      (el_valid && (el_idx == $past(el_idx) + 1'b1))); // R6

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (el_valid && !el_ready) |=> (el_valid && $stable(el_idx) && $stable(el_rd))); // R6

  AST_WB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (el_valid && el_ready && el_en) |=> !el_valid); // R7

  AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !el_valid && !in_ready) |=> (!el_valid && in_ready)); // R8

  AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ill |-> (!el_valid && in_ready)); // R10
endmodule

bind vs_seq vs_seq_chk #(.IW(IW), .RW(RW)) u_vs_seq_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .el_valid(el_valid),
  .el_ready(el_ready), .el_en(el_en), .el_last(el_last), .el_idx(el_idx),
  .el_rd(el_rd), .fault(fault), .ill(ill)
);

// File: tb/tb_vs_seq.sv
`timescale 1ns/1ps
module tb_vs_seq;
  logic        clk, rst_n;
  logic        cfg_we, cfg_sel, cfg_valid, cfg_fp;
  logic [1:0]  cfg_mode, priv_mode;
  logic [3:0]  cfg_slot;
  logic [4:0]  cfg_arch, cfg_dest;
  logic        in_valid, in_ready, in_fp;
  logic [4:0]  in_rd, in_rs1, in_rs2, in_vl, pred_addr;
  logic [15:0] pred_bits;
  logic        el_valid, el_ready, el_fp, el_en, el_last, wb_ack, fault, ill;
  logic [3:0]  el_idx, resume_idx;
  logic [4:0]  el_rd, el_rs1, el_rs2;

  int nchk = 0;
  int nfail = 0;

  // bench-side model of tables: [table][mode][slot]
  int t_v  [2][3][16];
  int t_fp [2][3][16];
  int t_a  [2][3][16];
  int t_d  [2][3][16];
  int msaved [3];

  vs_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode),
    .cfg_slot(cfg_slot), .cfg_valid(cfg_valid), .cfg_fp(cfg_fp), .cfg_arch(cfg_arch),
    .cfg_dest(cfg_dest), .priv_mode(priv_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_fp(in_fp), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_vl(in_vl),
    .pred_addr(pred_addr), .pred_bits(pred_bits), .el_valid(el_valid), .el_ready(el_ready),
    .el_idx(el_idx), .el_fp(el_fp), .el_rd(el_rd), .el_rs1(el_rs1), .el_rs2(el_rs2),
    .el_en(el_en), .el_last(el_last), .wb_ack(wb_ack), .fault(fault), .ill(ill),
    .resume_idx(resume_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(int act, int exp, string req, string what);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int look(int tb, int m, int fp, int arch, output int dest);
    dest = 0;
    if (m > 2) return 0;
    for (int e = 0; e < 16; e++) begin
      if (t_v[tb][m][e] != 0 && t_fp[tb][m][e] == fp && t_a[tb][m][e] == arch) begin
        dest = t_d[tb][m][e];
        return 1;
      end
    end
    return 0;
  endfunction

  task automatic cfg(int sel, int m, int slot, int v, int fp, int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel[0]; cfg_mode = m[1:0]; cfg_slot = slot[3:0];
    cfg_valid = v[0]; cfg_fp = fp[0]; cfg_arch = a[4:0]; cfg_dest = d[4:0];
    if (m < 3) begin
      t_v[sel][m][slot] = v; t_fp[sel][m][slot] = fp;
      t_a[sel][m][slot] = a; t_d[sel][m][slot] = d;
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Issue one instruction, follow every element cycle by cycle against the model.
  task automatic run(int fp, int rd, int rs1, int rs2, int vl, int pb, int fault_at, string req);
    int regs[3]; int base[3]; int vec[3]; int d;
    int anyv, multi, n, illx, ph, pd, mask, st, m;
    m = priv_mode;
    regs[0] = rd; regs[1] = rs1; regs[2] = rs2;
    anyv = 0;
    for (int k = 0; k < 3; k++) begin
      vec[k] = look(0, m, fp, regs[k], d);
      base[k] = vec[k] ? d : regs[k];
      anyv |= vec[k];
    end
    multi = anyv && vl > 1;
    if (!multi) begin
      for (int k = 0; k < 3; k++) begin vec[k] = 0; base[k] = regs[k]; end
    end
    n = multi ? vl : 1;
    illx = multi && vl > 16;
    for (int k = 0; k < 3; k++) if (multi && vec[k] && base[k] + vl - 1 > 31) illx = 1;
    ph = look(1, m, fp, rd, pd);
    mask = (multi && ph) ? pb : 'hFFFF;
    st = (m < 3 && msaved[m] < n) ? msaved[m] : 0;

    @(negedge clk);
    chk(in_ready, 1, "R6", "ready before request");
    in_valid = 1; in_fp = fp[0]; in_rd = rd[4:0]; in_rs1 = rs1[4:0]; in_rs2 = rs2[4:0];
    in_vl = vl[4:0]; pred_bits = pb[15:0];
    #1;
    chk(pred_addr, ph ? pd : 0, "R5", {req, " pred_addr"});
    @(negedge clk);
    in_valid = 0;
    if (illx) begin
      chk(ill, 1, "R10", {req, " ill pulse"});
      chk(el_valid, 0, "R10", {req, " no element"});
      @(negedge clk);
      chk(ill, 0, "R10", {req, " ill single cycle"});
      chk(el_valid, 0, "R10", {req, " still no element"});
      return;
    end
    chk(ill, 0, "R10", {req, " no ill"});
    for (int i = st; i < n; i++) begin
      int en;
      en = (mask >> i) & 1;
      chk(el_valid, 1, "R6", {req, " element present"});
      chk(el_idx, i, "R6", {req, " el_idx"});
      chk(el_rd, base[0] + (vec[0] ? i : 0), req, "el_rd");
      chk(el_rs1, base[1] + (vec[1] ? i : 0), req, "el_rs1");
      chk(el_rs2, base[2] + (vec[2] ? i : 0), req, "el_rs2");
      chk(el_en, en, "R5", {req, " el_en"});
      chk(el_last, (i == n - 1) ? 1 : 0, "R6", {req, " el_last"});
      chk(el_fp, fp, "R3", {req, " el_fp"});
      chk(in_ready, 0, "R6", {req, " busy"});
      @(negedge clk);
      if (en != 0) begin
        chk(el_valid, 0, "R7", {req, " wait for write-back"});
        if (i == fault_at) fault = 1; else wb_ack = 1;
        @(negedge clk);
        fault = 0; wb_ack = 0;
        if (i == fault_at) begin
          msaved[m] = i;
          chk(el_valid, 0, "R8", {req, " stop after fault"});
          chk(in_ready, 1, "R8", {req, " idle after fault"});
          chk(resume_idx, i, "R8", {req, " saved index"});
          return;
        end
      end
    end
    if (m < 3) msaved[m] = 0;
    chk(el_valid, 0, "R6", {req, " done"});
    chk(in_ready, 1, "R6", {req, " ready after"});
    chk(resume_idx, 0, "R8", {req, " saved index cleared"});
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 3; m++)
        for (int e = 0; e < 16; e++) begin
          t_v[s][m][e] = 0; t_fp[s][m][e] = 0; t_a[s][m][e] = 0; t_d[s][m][e] = 0;
        end
    for (int m = 0; m < 3; m++) msaved[m] = 0;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_mode = 0; cfg_slot = 0; cfg_valid = 0;
    cfg_fp = 0; cfg_arch = 0; cfg_dest = 0; priv_mode = 0; in_valid = 0; in_fp = 0;
    in_rd = 0; in_rs1 = 0; in_rs2 = 0; in_vl = 0; pred_bits = 0; el_ready = 1;
    wb_ack = 0; fault = 0;
    repeat (3) @(negedge clk);
    chk(in_ready, 1, "R1", "reset in_ready");
    chk(el_valid, 0, "R1", "reset el_valid");
    chk(el_en, 0, "R1", "reset el_en");
    chk(ill, 0, "R1", "reset ill");
    chk(resume_idx, 0, "R1", "reset resume_idx");
    rst_n = 1;
    @(negedge clk);

    // R4: no tags at all, then length 0 with a tag present
    run(0, 10, 20, 30, 3, 'hFFFF, -1, "R4 untagged");
    cfg(0, 0, 0, 1, 0, 10, 10);
    cfg(0, 0, 1, 1, 0, 20, 20);
    cfg(0, 0, 2, 1, 0, 30, 30);
    run(0, 10, 20, 30, 0, 'hFFFF, -1, "R4 vl0");
    run(0, 10, 20, 30, 1, 'hFFFF, -1, "R4 vl1");
    // R2: contiguous runs, and a fixed untagged source
    run(0, 10, 20, 30, 2, 'hFFFF, -1, "R2 all tagged");
    run(0, 10, 20, 5, 4, 'hFFFF, -1, "R2 fixed rs2");
    // R3: redirection and class separation
    cfg(0, 0, 3, 1, 0, 3, 12);
    cfg(0, 0, 4, 1, 0, 5, 14);
    cfg(0, 0, 8, 1, 1, 3, 8);
    run(0, 3, 5, 7, 4, 'hFFFF, -1, "R3 redirect int");
    run(1, 3, 5, 7, 3, 'hFFFF, -1, "R3 redirect fp");
    // R5: predicate mask, then removal of the predicate entry
    cfg(1, 0, 0, 1, 0, 10, 6);
    run(0, 10, 20, 5, 4, 'h0005, -1, "R5 mask 0101");
    run(0, 10, 20, 5, 5, 'h0016, -1, "R5 mask 10110");
    cfg(1, 0, 0, 0, 0, 10, 6);
    run(0, 10, 20, 5, 3, 'h0000, -1, "R5 entry removed");
    // R11: lowest slot wins
    cfg(0, 0, 6, 1, 0, 9, 20);
    cfg(0, 0, 5, 1, 0, 9, 16);
    run(0, 9, 1, 2, 2, 'hFFFF, -1, "R11 slot5 wins");
    cfg(0, 0, 5, 0, 0, 9, 16);
    run(0, 9, 1, 2, 2, 'hFFFF, -1, "R11 slot6 after clear");
    // R10: range boundaries
    run(0, 10, 20, 30, 2, 'hFFFF, -1, "R10 ends at 31");
    run(0, 10, 20, 30, 3, 'hFFFF, -1, "R10 past 31");
    run(0, 10, 20, 5, 17, 'hFFFF, -1, "R10 length 17");
    run(0, 10, 20, 5, 16, 'hFFFF, -1, "R10 length 16");
    // R7 with overlapping runs: rd 12.. and rs1 14.. overlap
    run(0, 3, 5, 3, 6, 'hFFFF, -1, "R7 overlap");
    // R8 and R9: fault in user mode, interleaved with supervisor work
    run(0, 10, 20, 5, 4, 'hFFFF, 1, "R8 fault idx1");
    priv_mode = 1;
    @(negedge clk);
    chk(resume_idx, 0, "R9", "supervisor saved index separate");
    run(0, 10, 20, 5, 3, 'hFFFF, -1, "R9 supervisor no tags");
    priv_mode = 0;
    @(negedge clk);
    chk(resume_idx, 1, "R9", "user saved index kept");
    run(0, 10, 20, 5, 4, 'hFFFF, -1, "R8 resume from idx1");
    run(0, 10, 20, 5, 3, 'hFFFF, 0, "R8 fault idx0");
    run(0, 10, 20, 5, 3, 'hFFFF, -1, "R8 resume from idx0");
    // R9: mode 3 writes dropped; machine-mode entry private
    cfg(0, 3, 7, 1, 0, 11, 11);
    run(0, 11, 1, 2, 2, 'hFFFF, -1, "R9 mode3 write dropped user");
    priv_mode = 2;
    run(0, 11, 1, 2, 2, 'hFFFF, -1, "R9 mode3 write dropped machine");
    cfg(0, 2, 0, 1, 0, 11, 11);
    run(0, 11, 1, 2, 3, 'hFFFF, -1, "R9 machine entry");
    priv_mode = 0;
    run(0, 11, 1, 2, 3, 'hFFFF, -1, "R9 user unaffected");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule